// File: doc/BRIEF.md
# Predicated Tile Row/Column Accumulator

This block holds one accumulator tile of a matrix unit and adds a source vector into it under control of two predicates. Each tile element (row, col) is updated only when the row predicate selects its row and the column predicate selects its column. In horizontal mode the element receives the source element that matches its column. In vertical mode the element receives the source element that matches its row, so one source element is broadcast across a row.

The vector length is a parameter, 128 bits by default. Elements are 32 or 64 bits wide, chosen per operation, giving a 4x4 or a 2x2 tile. A start pulse captures the operation. The engine then walks the tile one row per clock, doing a read-modify-write of that row. A single-cycle done pulse follows the last row. A simple load port writes whole tile rows while the engine is idle, and a registered read port returns any row one cycle after it is addressed.

Top module: `pacc_unit`

## Requirements
- R1: After reset, busy and done are low and every tile row reads as zero.
- R2: In horizontal mode (`vert_i`=0), each selected element (row, col) becomes its old value plus source element col.
- R3: In vertical mode (`vert_i`=1), each selected element (row, col) becomes its old value plus source element row.
- R4: With 32-bit elements (`wide_i`=0), row or column k is selected by predicate bit 4k. With 64-bit elements (`wide_i`=1), it is selected by bit 8k. All other predicate bits have no effect.
- R5: An element whose row or column is not selected keeps its old value.
- R6: Sums wrap modulo 2^32 for 32-bit elements, with no saturation.
- R7: With 64-bit elements, sums wrap modulo 2^64 and carry across the 32-bit halves. Only rows 0 and 1 form the tile, and rows 2 and 3 are left untouched.
- R8: Busy rises the cycle after an accepted start. It stays high for 4 cycles with 32-bit elements and 2 cycles with 64-bit elements. Done is high for exactly the one cycle after busy falls.
- R9: A start pulse that arrives while busy is high is ignored. It does not change the running operation and does not launch a second one.
- R10: While idle, a row write on the load port replaces that tile row. Writes made while busy are ignored. `rd_data_o` shows the row addressed by `rd_row_i` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; captures the operation when idle |
| vert_i | input | 1 | 0 horizontal (source indexed by column), 1 vertical (source indexed by row) |
| wide_i | input | 1 | 0 for 32-bit elements, 1 for 64-bit elements |
| src_i | input | VLEN | Source vector; element k is at bits k*ESZ upward |
| row_pred_i | input | VLEN/8 | Row predicate |
| col_pred_i | input | VLEN/8 | Column predicate |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse after the last row |
| ld_en_i | input | 1 | Tile row write enable (idle only) |
| ld_row_i | input | log2(VLEN/32) | Row to write |
| ld_data_i | input | VLEN | Row write data |
| rd_row_i | input | log2(VLEN/32) | Row to read |
| rd_data_o | output | VLEN | Registered row read data |

## Verification
The engine is driven with all-ones predicates so that every element is updated by its own column source. Sparse predicates are then used, with every non-decoded bit set, to show that only bits 4k or 8k take part and that an unselected row or column stays intact. Vertical runs use distinct source values per row, so a row-indexed result cannot be mistaken for a column-indexed one. Operands near the top of the range expose wrapping, and a low-half all-ones operand at 64 bits exposes the carry across the 32-bit boundary. Extra start and load pulses are injected mid-run; the result and the done timing must not change.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  typedef enum logic { DIR_BY_COL = 1'b0, DIR_BY_ROW = 1'b1 } acc_dir_e;
  typedef enum logic { ESZ_W32 = 1'b0, ESZ_W64 = 1'b1 } acc_esz_e;
endpackage

// File: rtl/pacc_tile.sv
module pacc_tile #(
  parameter int VLEN  = 128,
  parameter int NROWS = VLEN / 32,
  localparam int RW   = $clog2(NROWS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [RW-1:0]   wrow,
  input  logic [VLEN-1:0] wdata,
  input  logic [RW-1:0]   arow,
  output logic [VLEN-1:0] adata,
  input  logic [RW-1:0]   rrow,
  output logic [VLEN-1:0] rdata
);
  logic [VLEN-1:0] mem [NROWS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NROWS; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) mem[wrow] <= wdata;
      rdata <= mem[rrow];
    end
  end

  assign adata = mem[arow];
endmodule

// File: rtl/pacc_row_alu.sv
module pacc_row_alu
  import pacc_pkg::*;
#(
  parameter int VLEN = 128,
  localparam int NL  = VLEN / 32,
  localparam int ND  = VLEN / 64,
  localparam int RW  = $clog2(NL)
) (
  input  logic [VLEN-1:0] old_row,
  input  logic [VLEN-1:0] src,
  input  logic [NL-1:0]   col_en32,
  input  logic [ND-1:0]   col_en64,
  input  logic            row_act,
  input  acc_dir_e        dir,
  input  acc_esz_e        esz,
  input  logic [RW-1:0]   row_idx,
  output logic [VLEN-1:0] new_row
);
  logic [31:0] bcast32;
  logic [63:0] bcast64;

  always_comb begin
    bcast32 = '0;
    bcast64 = '0;
    for (int k = 0; k < NL; k++)
      if (row_idx == RW'(k)) bcast32 = src[k*32 +: 32];
    for (int d = 0; d < ND; d++)
      if (row_idx == RW'(d)) bcast64 = src[d*64 +: 64];
  end

  for (genvar c = 0; c < ND; c++) begin : g_dw
    logic [63:0] old64, add64, sum64, res64;
    logic [63:0] res32pair;
    assign old64 = old_row[c*64 +: 64];
    assign add64 = (dir == DIR_BY_ROW) ? bcast64 : src[c*64 +: 64];
    assign sum64 = old64 + add64;
    assign res64 = (row_act && col_en64[c]) ? sum64 : old64;
    for (genvar h = 0; h < 2; h++) begin : g_lane
      localparam int L = 2 * c + h;
      logic [31:0] old32, add32, sum32;
      assign old32 = old_row[L*32 +: 32];
      assign add32 = (dir == DIR_BY_ROW) ? bcast32 : src[L*32 +: 32];
      assign sum32 = old32 + add32;
      assign res32pair[h*32 +: 32] = (row_act && col_en32[L]) ? sum32 : old32;
    end
    assign new_row[c*64 +: 64] = (esz == ESZ_W64) ? res64 : res32pair;
  end

  // R5: an unselected row passes through unchanged
  always_comb begin
    if (!row_act) begin
      p_idle_row_kept_r5: assert (new_row == old_row);
    end
  end
endmodule

// File: rtl/pacc_unit.sv
module pacc_unit
  import pacc_pkg::*;
#(
  parameter int VLEN = 128,
  localparam int NL  = VLEN / 32,
  localparam int ND  = VLEN / 64,
  localparam int PW  = VLEN / 8,
  localparam int RW  = $clog2(NL)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            vert_i,
  input  logic            wide_i,
  input  logic [VLEN-1:0] src_i,
  input  logic [PW-1:0]   row_pred_i,
  input  logic [PW-1:0]   col_pred_i,
  output logic            busy_o,
  output logic            done_o,
  input  logic            ld_en_i,
  input  logic [RW-1:0]   ld_row_i,
  input  logic [VLEN-1:0] ld_data_i,
  input  logic [RW-1:0]   rd_row_i,
  output logic [VLEN-1:0] rd_data_o
);
  // predicate expansion: 32-bit element k -> bit 4k, 64-bit element k -> bit 8k
  logic [NL-1:0] rsel32, csel32, rsel64;
  logic [ND-1:0] csel64;
  for (genvar k = 0; k < NL; k++) begin : g_pexp
    assign rsel32[k] = row_pred_i[4*k];
    assign csel32[k] = col_pred_i[4*k];
    if (k < ND) begin : g_w
      assign rsel64[k] = row_pred_i[8*k];
      assign csel64[k] = col_pred_i[8*k];
    end else begin : g_pad
      assign rsel64[k] = 1'b0;
    end
  end
  logic unused_pred;
  assign unused_pred = ^{row_pred_i, col_pred_i};

  acc_dir_e        dir_q;
  acc_esz_e        esz_q;
  logic [VLEN-1:0] src_q;
  logic [NL-1:0]   rsel32_q, csel32_q, rsel64_q;
  logic [ND-1:0]   csel64_q;
  logic [RW-1:0]   row_q, last_row;
  logic            busy_q, done_q, row_act;
  logic [VLEN-1:0] cur_row, upd_row;

  assign last_row = (esz_q == ESZ_W64) ? RW'(ND - 1) : RW'(NL - 1);
  assign row_act  = (esz_q == ESZ_W64) ? rsel64_q[row_q] : rsel32_q[row_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      row_q    <= '0;
      dir_q    <= DIR_BY_COL;
      esz_q    <= ESZ_W32;
      src_q    <= '0;
      rsel32_q <= '0;
      csel32_q <= '0;
      rsel64_q <= '0;
      csel64_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start_i) begin
        busy_q   <= 1'b1;
        row_q    <= '0;
        dir_q    <= acc_dir_e'(vert_i);
        esz_q    <= acc_esz_e'(wide_i);
        src_q    <= src_i;
        rsel32_q <= rsel32;
        csel32_q <= csel32;
        rsel64_q <= rsel64;
        csel64_q <= csel64;
      end else if (busy_q) begin
        row_q <= row_q + RW'(1);
        if (row_q == last_row) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  pacc_row_alu #(.VLEN(VLEN)) u_alu (
    .old_row (cur_row),
    .src     (src_q),
    .col_en32(csel32_q),
    .col_en64(csel64_q),
    .row_act (row_act),
    .dir     (dir_q),
    .esz     (esz_q),
    .row_idx (row_q),
    .new_row (upd_row)
  );

  pacc_tile #(.VLEN(VLEN), .NROWS(NL)) u_tile (
    .clk  (clk),
    .rst  (rst),
    .we   (busy_q | ld_en_i),
    .wrow (busy_q ? row_q : ld_row_i),
    .wdata(busy_q ? upd_row : ld_data_i),
    .arow (row_q),
    .adata(cur_row),
    .rrow (rd_row_i),
    .rdata(rd_data_o)
  );

  assign busy_o = busy_q;
  assign done_o = done_q;

  p_row_limit_r8: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> row_q <= last_row);
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  p_done_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> done_q);
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i) |=> ($stable(src_q) && $stable(dir_q) && $stable(esz_q)));
endmodule

// File: tb/pacc_unit_tb.sv
`timescale 1ns/1ps
module pacc_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst;
  logic         start, vert, wide, we;
  logic [127:0] src, wdata;
  logic [15:0]  rp, cp;
  logic [1:0]   wrow, rrow;
  logic         busy, done;
  logic [127:0] rdata;
  logic [127:0] exp_t [4];
  int           nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  pacc_unit #(.VLEN(128)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .vert_i(vert), .wide_i(wide),
    .src_i(src), .row_pred_i(rp), .col_pred_i(cp),
    .busy_o(busy), .done_o(done),
    .ld_en_i(we), .ld_row_i(wrow), .ld_data_i(wdata),
    .rd_row_i(rrow), .rd_data_o(rdata)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic verify_tile(input string tag);
    for (int r = 0; r < 4; r++) begin
      @(negedge clk) rrow = 2'(r);
      @(negedge clk) chk(tag, rdata, exp_t[r]);
    end
  endtask

  task automatic load_row(input int r, input logic [127:0] d);
    @(negedge clk) begin we = 1'b1; wrow = 2'(r); wdata = d; end
    @(negedge clk) we = 1'b0;
    exp_t[r] = d;
  endtask

  task automatic model(input logic v, input logic w, input logic [127:0] s,
                       input logic [15:0] rpv, input logic [15:0] cpv);
    if (!w) begin
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++)
          if (rpv[4*r] && cpv[4*c])
            exp_t[r][32*c +: 32] = exp_t[r][32*c +: 32] + (v ? s[32*r +: 32] : s[32*c +: 32]);
    end else begin
      for (int r = 0; r < 2; r++)
        for (int c = 0; c < 2; c++)
          if (rpv[8*r] && cpv[8*c])
            exp_t[r][64*c +: 64] = exp_t[r][64*c +: 64] + (v ? s[64*r +: 64] : s[64*c +: 64]);
    end
  endtask

  task automatic run_op(input logic v, input logic w, input logic [127:0] s,
                        input logic [15:0] rpv, input logic [15:0] cpv,
                        input bit intr_start, input bit intr_load);
    int k;
    int rows;
    rows = w ? 2 : 4;
    model(v, w, s, rpv, cpv);
    @(negedge clk) begin start = 1'b1; vert = v; wide = w; src = s; rp = rpv; cp = cpv; end
    @(negedge clk) start = 1'b0;
    chk("R8 busy after start", {127'b0, busy}, 128'd1);
    k = 0;
    while (k < 20) begin
      @(negedge clk);
      k++;
      if (done) break;
      if (intr_start && k == 1) begin
        start = 1'b1; src = ~s; vert = ~v; rp = 16'hFFFF; cp = 16'hFFFF;
      end else start = 1'b0;
      if (intr_load && k == 1) begin
        we = 1'b1; wrow = 2'd3; wdata = {4{32'hDEAD_BEEF}};
      end else we = 1'b0;
    end
    start = 1'b0;
    we = 1'b0;
    chk("R8 cycles to done", 128'(k), 128'(rows));
    chk("R8 busy low with done", {127'b0, busy}, 128'd0);
    @(negedge clk);
    chk("R8 R9 done single and no relaunch", {126'b0, busy, done}, 128'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R8 watchdog act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  task automatic t_reset;
    for (int r = 0; r < 4; r++) exp_t[r] = '0;
    chk("R1 busy", {127'b0, busy}, 128'd0);
    chk("R1 done", {127'b0, done}, 128'd0);
    verify_tile("R1 tile zero");
  endtask

  task automatic t_port;
    load_row(0, 128'h0000_0001_0000_0002_0000_0003_0000_0004);
    load_row(1, 128'h1111_1111_2222_2222_3333_3333_4444_4444);
    load_row(2, 128'h0000_0100_0000_0200_0000_0300_0000_0400);
    load_row(3, 128'hA000_0000_B000_0000_C000_0000_D000_0000);
    verify_tile("R10 load port");
  endtask

  task automatic t_horiz;
    run_op(1'b0, 1'b0, {32'h40, 32'h30, 32'h20, 32'h10}, 16'hFFFF, 16'hFFFF, 0, 0);
    verify_tile("R2 horizontal all active");
  endtask

  task automatic t_vert;
    // rows 0,1 and column 3 only; undecoded bits set
    run_op(1'b1, 1'b0, {32'h4000, 32'h3000, 32'h2000, 32'h1000}, 16'hEEF1, 16'h1E0E, 0, 0);
    verify_tile("R3 R4 R5 vertical sparse");
  endtask

  task automatic t_wrap;
    load_row(2, {32'hFFFF_FFFF, 32'hFFFF_FFF0, 32'h8000_0000, 32'h1});
    run_op(1'b0, 1'b0, {32'h2, 32'h20, 32'h8000_0000, 32'h5}, 16'h0100, 16'hFFFF, 0, 0);
    chk("R6 wrap value", exp_t[2], {32'h1, 32'h10, 32'h0, 32'h6});
    verify_tile("R6 R5 wrap");
  endtask

  task automatic t_wide;
    load_row(0, {64'h0, 64'h0000_0000_FFFF_FFFF});
    // row 0 only (bit4 stray), both 64-bit columns; load during busy ignored
    run_op(1'b0, 1'b1, {64'h1, 64'h1}, 16'h00FF, 16'hFF01, 0, 1);
    chk("R7 carry", exp_t[0], {64'h1, 64'h0000_0001_0000_0000});
    verify_tile("R7 R10 wide horizontal");
  endtask

  task automatic t_wide_vert;
    run_op(1'b1, 1'b1, {64'h0000_0002_0000_0000, 64'h7}, 16'h0101, 16'h0100, 1, 0);
    verify_tile("R9 R3 wide vertical");
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; vert = 1'b0; wide = 1'b0; we = 1'b0;
    src = '0; wdata = '0; rp = '0; cp = '0; wrow = '0; rrow = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_port();
    t_horiz();
    t_vert();
    t_wrap();
    t_wide();
    t_wide_vert();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule